// File: doc/BRIEF.md
# Receive-Enable Rank Merge Stage

This block finishes receive-enable training for one byte lane at a time. It takes three things: the 8-bit phase-recovery delay that the phy measured for that lane, the lane's stored training word, and the chip-select context. From these it works out the final receive-enable delay and the new contents of the stored word. It also decides whether the delay should be programmed now.

The stored word carries a gross-delay remainder that the seed stage saved at bit 6 and above. It can also hold a parked result in its low bits. The block recovers the remainder, adds it to the measured value and adds one unit interval (0x20) so that the delay sits at the middle of the DQS preamble. The chip select and the present mask then pick one of three outcomes:
- On an even rank with no partner, the result is stored and programmed.
- On an even rank whose odd partner is present, the result is parked by OR-ing it into the stored word, and nothing is programmed.
- On an odd rank, the parked value and the new result are averaged, rounding up, and the average is stored and programmed.

A request is accepted when `req_valid` and `req_ready` are both high. Its response appears, registered, on the following cycle.

Top module: `rxen_rank_merge`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it, the outputs `rsp_valid`, `prog_en`, `entry_out` and `prog_dly` are all zero. `req_ready` is low during reset and goes high on the first rising edge with `rst_n` high. It then stays high.
- R2: A request accepted at a rising edge gives `rsp_valid` high for exactly the next cycle. Back-to-back requests give back-to-back responses.
- R3: The remainder is ((`entry_in` >> 6) AND 0x1E0). Bits of the shifted entry outside that mask have no effect on the result.
- R4: The lane result is the zero-extended `meas_dly`, plus the remainder, plus 0x20.
- R5: For an even `cs_idx` whose partner bit `cs_mask[cs_idx+1]` is 1, `entry_out` = `entry_in` OR result and `prog_en` = 0.
- R6: For an even `cs_idx` whose partner bit is 0, `entry_out` = result and `prog_en` = 1, with `prog_dly` = result[9:0].
- R7: For an odd `cs_idx`, the value v = ((`entry_in` AND 0x3FF) + result + 1) / 2 with the fraction dropped. Then `entry_out` = v, `prog_en` = 1 and `prog_dly` = v[9:0].
- R8: The partner test reads only mask bit `cs_idx+1`. The other mask bits, including bit `cs_idx` itself, do not change the outcome.
- R9: All sums are formed at 16 bits. Whenever `prog_en` is 1, `prog_dly` equals `entry_out[9:0]`.
- R10: A cycle with `req_valid` low gives `rsp_valid` = 0 and `prog_en` = 0 on the next cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Stage can accept a request |
| meas_dly | input | 8 | Measured phase-recovery delay for the lane |
| entry_in | input | 16 | Stored lane word: remainder in upper bits, parked result in low bits |
| cs_idx | input | 3 | Chip select being trained |
| cs_mask | input | 8 | Present chip selects, one bit each |
| rsp_valid | output | 1 | Response present this cycle |
| entry_out | output | 16 | Updated stored lane word |
| prog_en | output | 1 | Program the delay this cycle |
| prog_dly | output | 10 | Receive-enable delay to program |

## Verification
The bench goes after the low-order bits of the stored word.

If a design fails to mask the remainder, `entry_out` changes when the word holds a parked result or stray low bits. If it averages without the +1, an odd sum rounds down.

Mask patterns test whether the partner lookup uses bit `cs_idx+1` and no other. A design that tests the wrong bit parks a single-rank result, or programs the first of a pair.

Finally, the bench runs a full park-then-average sequence, a request with the largest values, and idle cycles with the inputs changing. These catch a design that loses the parked value, overflows a narrow adder, or responds without a request.

// File: rtl/rxm_pkg.sv
// Package: shared constants and types for the receive-enable rank merge stage.
// Assumes the stored word layout: remainder at bit REM_SHIFT and up, parked
// result in the low AVG_BITS bits.
package rxm_pkg;
    localparam int SUM_W     = 16;
    localparam int REM_SHIFT = 6;
    localparam int AVG_BITS  = 10;
    localparam logic [SUM_W-1:0] REM_MASK = 16'h01E0;
    localparam logic [SUM_W-1:0] UI_STEP  = 16'h0020;
    localparam logic [SUM_W-1:0] AVG_MASK = (16'h1 << AVG_BITS) - 16'h1;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_PARK    = 2'd1,
        MODE_AVERAGE = 2'd2
    } merge_mode_e;
endpackage

// File: rtl/rxm_final_calc.sv
// Module: computes the remainder and the final lane delay.
// Assumes the measured value is unsigned and no wider than the sum width.
module rxm_final_calc
    import rxm_pkg::*;
#(
    parameter int MEAS_W  = 8,
    parameter int ENTRY_W = 16
) (
    input  logic [MEAS_W-1:0]  meas,
    input  logic [ENTRY_W-1:0] entry,
    output logic [SUM_W-1:0]   remainder,
    output logic [SUM_W-1:0]   result
);
    localparam int PAD_W = SUM_W - MEAS_W;

    logic [SUM_W-1:0] entry_ext;
    logic [SUM_W-1:0] meas_ext;

    // Widen both operands to the sum width.
    always_comb begin
        entry_ext = SUM_W'(entry);
        meas_ext  = {{PAD_W{1'b0}}, meas};
    end

    // Recover the saved remainder and add one UI for the preamble midpoint.
    always_comb begin
        remainder = (entry_ext >> REM_SHIFT) & REM_MASK;
        result    = meas_ext + remainder + UI_STEP;
    end
endmodule

// File: rtl/rxm_mode_decode.sv
// Module: picks single, park or average from the chip select and present mask.
// Assumes ranks pair as (even, even+1) and that the partner of the top even
// index exists only if it lies inside the mask.
module rxm_mode_decode
    import rxm_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CS_W   = 3
) (
    input  logic [CS_W-1:0]   cs_idx,
    input  logic [NUM_CS-1:0] cs_mask,
    output merge_mode_e       mode
);
    logic [NUM_CS-1:0] partner_here;

    // One partner flag per even index, read from the next-higher mask bit.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_partner
        if ((i % 2 == 0) && (i + 1 < NUM_CS)) begin : g_even
            assign partner_here[i] = cs_mask[i+1];
        end else begin : g_other
            assign partner_here[i] = 1'b0;
        end
    end

    // Odd ranks average; even ranks park if a partner is present.
    always_comb begin
        if (cs_idx[0]) begin
            mode = MODE_AVERAGE;
        end else if ((32'(cs_idx) < NUM_CS) && partner_here[cs_idx]) begin
            mode = MODE_PARK;
        end else begin
            mode = MODE_SINGLE;
        end
    end
endmodule

// File: rtl/rxm_merge.sv
// Module: forms the new stored word, the program strobe and the program value.
// Assumes the result already includes the remainder and the UI step.
module rxm_merge
    import rxm_pkg::*;
#(
    parameter int ENTRY_W = 16,
    parameter int DLY_W   = 10
) (
    input  merge_mode_e        mode,
    input  logic [ENTRY_W-1:0] entry,
    input  logic [SUM_W-1:0]   result,
    output logic [ENTRY_W-1:0] entry_nxt,
    output logic               prog_nxt,
    output logic [DLY_W-1:0]   dly_nxt
);
    logic [SUM_W-1:0] avg_sum;
    logic [SUM_W-1:0] avg_val;
    logic [SUM_W-1:0] word;

    // Rounded-up average of the parked first-rank value and the new result.
    always_comb begin
        avg_sum = (SUM_W'(entry) & AVG_MASK) + result + 16'd1;
        avg_val = avg_sum >> 1;
    end

    // Select the stored word and strobe for the mode.
    always_comb begin
        unique case (mode)
            MODE_PARK: begin
                word     = SUM_W'(entry) | result;
                prog_nxt = 1'b0;
                dly_nxt  = result[DLY_W-1:0];
            end
            MODE_AVERAGE: begin
                word     = avg_val;
                prog_nxt = 1'b1;
                dly_nxt  = avg_val[DLY_W-1:0];
            end
            default: begin
                word     = result;
                prog_nxt = 1'b1;
                dly_nxt  = result[DLY_W-1:0];
            end
        endcase
        entry_nxt = word[ENTRY_W-1:0];
    end
endmodule

// File: rtl/rxm_resp_reg.sv
// Module: response register stage and ready flag.
// Assumes synchronous active-low reset; no downstream backpressure.
module rxm_resp_reg #(
    parameter int ENTRY_W = 16,
    parameter int DLY_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [ENTRY_W-1:0] entry_nxt,
    input  logic               prog_nxt,
    input  logic [DLY_W-1:0]   dly_nxt,
    output logic               ready,
    output logic               rsp_valid,
    output logic [ENTRY_W-1:0] entry_q,
    output logic               prog_q,
    output logic [DLY_W-1:0]   dly_q
);
    // Ready rises on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= 1'b1;
    end

    // Capture the response of an accepted request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            entry_q   <= '0;
            prog_q    <= 1'b0;
            dly_q     <= '0;
        end else begin
            rsp_valid <= accept;
            prog_q    <= accept & prog_nxt;
            if (accept) begin
                entry_q <= entry_nxt;
                dly_q   <= dly_nxt;
            end
        end
    end
endmodule

// File: rtl/rxen_rank_merge.sv
// Top: final receive-enable delay and dual-rank merge, one lane per request.
// Assumes the seed stage left the remainder in the stored word at bit 6 and up.
module rxen_rank_merge
    import rxm_pkg::*;
#(
    parameter int MEAS_W  = 8,
    parameter int ENTRY_W = 16,
    parameter int DLY_W   = 10,
    parameter int NUM_CS  = 8,
    parameter int CS_W    = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [MEAS_W-1:0]  meas_dly,
    input  logic [ENTRY_W-1:0] entry_in,
    input  logic [CS_W-1:0]    cs_idx,
    input  logic [NUM_CS-1:0]  cs_mask,
    output logic               rsp_valid,
    output logic [ENTRY_W-1:0] entry_out,
    output logic               prog_en,
    output logic [DLY_W-1:0]   prog_dly
);
    logic [SUM_W-1:0]   remainder;
    logic [SUM_W-1:0]   result;
    merge_mode_e        mode;
    logic [ENTRY_W-1:0] entry_nxt;
    logic               prog_nxt;
    logic [DLY_W-1:0]   dly_nxt;
    logic               accept;

    // Handshake: a request is taken when both sides agree.
    always_comb accept = req_valid & req_ready;

    rxm_final_calc #(.MEAS_W(MEAS_W), .ENTRY_W(ENTRY_W)) u_calc (
        .meas      (meas_dly),
        .entry     (entry_in),
        .remainder (remainder),
        .result    (result)
    );

    rxm_mode_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_mode (
        .cs_idx  (cs_idx),
        .cs_mask (cs_mask),
        .mode    (mode)
    );

    rxm_merge #(.ENTRY_W(ENTRY_W), .DLY_W(DLY_W)) u_merge (
        .mode      (mode),
        .entry     (entry_in),
        .result    (result),
        .entry_nxt (entry_nxt),
        .prog_nxt  (prog_nxt),
        .dly_nxt   (dly_nxt)
    );

    rxm_resp_reg #(.ENTRY_W(ENTRY_W), .DLY_W(DLY_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .entry_nxt (entry_nxt),
        .prog_nxt  (prog_nxt),
        .dly_nxt   (dly_nxt),
        .ready     (req_ready),
        .rsp_valid (rsp_valid),
        .entry_q   (entry_out),
        .prog_q    (prog_en),
        .dly_q     (prog_dly)
    );
endmodule

// File: rtl/rxen_rank_merge_chk.sv
// Checker: port-level timing and mode properties of the rank merge stage.
module rxen_rank_merge_chk #(
    parameter int ENTRY_W = 16,
    parameter int DLY_W   = 10,
    parameter int NUM_CS  = 8,
    parameter int CS_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [CS_W-1:0]    cs_idx,
    input logic [NUM_CS-1:0]  cs_mask,
    input logic               rsp_valid,
    input logic [ENTRY_W-1:0] entry_out,
    input logic               prog_en,
    input logic [DLY_W-1:0]   prog_dly
);
    // R2: an accepted request gives a response next cycle.
    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R10: no request, no response.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (!rsp_valid && !prog_en));

    // R7: odd chip select always programs.
    a_r7_odd_programs: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cs_idx[0]) |=> prog_en);

    // R5: even rank with present partner does not program.
    a_r5_park_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cs_idx[0] && (32'(cs_idx) + 1 < NUM_CS)
         && cs_mask[cs_idx + 1'b1]) |=> !prog_en);

    // R9: programmed value matches the low bits of the stored word.
    a_r9_prog_matches: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (rsp_valid && prog_dly == entry_out[DLY_W-1:0]));

    // R1: ready stays high once out of reset.
    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);
endmodule

bind rxen_rank_merge rxen_rank_merge_chk #(
    .ENTRY_W(ENTRY_W), .DLY_W(DLY_W), .NUM_CS(NUM_CS), .CS_W(CS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cs_idx    (cs_idx),
    .cs_mask   (cs_mask),
    .rsp_valid (rsp_valid),
    .entry_out (entry_out),
    .prog_en   (prog_en),
    .prog_dly  (prog_dly)
);

// File: tb/rxen_rank_merge_tb.sv
// Directed bench for the receive-enable rank merge stage.
module rxen_rank_merge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  meas_dly = '0;
    logic [15:0] entry_in = '0;
    logic [2:0]  cs_idx = '0;
    logic [7:0]  cs_mask = '0;
    logic        rsp_valid;
    logic [15:0] entry_out;
    logic        prog_en;
    logic [9:0]  prog_dly;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rxen_rank_merge u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .meas_dly(meas_dly), .entry_in(entry_in), .cs_idx(cs_idx), .cs_mask(cs_mask),
        .rsp_valid(rsp_valid), .entry_out(entry_out), .prog_en(prog_en), .prog_dly(prog_dly)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected response from the requirement formulas.
    task automatic model(input logic [7:0] m, input logic [15:0] e,
                         input logic [2:0] cs, input logic [7:0] mask,
                         output logic [15:0] xe, output logic xp, output logic [9:0] xd);
        logic [15:0] rem, res, v;
        rem = (e >> 6) & 16'h01E0;
        res = {8'h00, m} + rem + 16'h0020;
        if (cs[0]) begin
            v  = ((e & 16'h03FF) + res + 16'd1) >> 1;
            xe = v; xp = 1'b1; xd = v[9:0];
        end else if (mask[cs + 3'd1]) begin
            xe = e | res; xp = 1'b0; xd = res[9:0];
        end else begin
            xe = res; xp = 1'b1; xd = res[9:0];
        end
    endtask

    // One request; response sampled on the following falling edge.
    task automatic send(input string req, input logic [7:0] m, input logic [15:0] e,
                        input logic [2:0] cs, input logic [7:0] mask,
                        input logic [15:0] xe, input logic xp, input logic [9:0] xd);
        @(negedge clk);
        req_valid = 1'b1; meas_dly = m; entry_in = e; cs_idx = cs; cs_mask = mask;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(req, "entry_out", 32'(entry_out), 32'(xe));
        check(req, "prog_en",   32'(prog_en),   32'(xp));
        if (xp) check(req, "prog_dly", 32'(prog_dly), 32'(xd));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        check("R1", "prog_en", 32'(prog_en), 0);
        check("R1", "entry_out", 32'(entry_out), 0);
        check("R1", "prog_dly", 32'(prog_dly), 0);
        check("R1", "ready_in_reset", 32'(req_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready_after", 32'(req_ready), 1);
        check("R1", "rsp_after", 32'(rsp_valid), 0);
    endtask

    task automatic t_single();
        send("R6", 8'h15, 16'h1000, 3'd0, 8'h01, 16'h0075, 1'b1, 10'h075);
        send("R4", 8'h00, 16'h0000, 3'd2, 8'h04, 16'h0020, 1'b1, 10'h020);
    endtask

    task automatic t_remainder();
        // R3: low bits and the bits below 0x20 of the shifted word drop out.
        send("R3", 8'h15, 16'h103F, 3'd0, 8'h01, 16'h0075, 1'b1, 10'h075);
        send("R3", 8'h10, 16'h07C0, 3'd0, 8'h01, 16'h0030, 1'b1, 10'h030);
    endtask

    task automatic t_pair();
        // R5 park then R7 average of the same lane.
        send("R5", 8'h15, 16'h1000, 3'd2, 8'h0C, 16'h1075, 1'b0, 10'h000);
        send("R7", 8'h18, 16'h1075, 3'd3, 8'h0C, 16'h0077, 1'b1, 10'h077);
        // R7 rounding up of an odd sum: (0x20 + 0x21 + 1)/2 = 0x21.
        send("R7", 8'h01, 16'h0020, 3'd1, 8'h03, 16'h0021, 1'b1, 10'h021);
    endtask

    task automatic t_mask();
        logic [15:0] xe; logic xp; logic [9:0] xd;
        // R8: only bit cs+1 matters.
        model(8'h22, 16'h0800, 3'd0, 8'hFC, xe, xp, xd);
        send("R8", 8'h22, 16'h0800, 3'd0, 8'hFC, xe, xp, xd);
        model(8'h22, 16'h0800, 3'd4, 8'h20, xe, xp, xd);
        send("R8", 8'h22, 16'h0800, 3'd4, 8'h20, xe, xp, xd);
        model(8'h22, 16'h0800, 3'd6, 8'h40, xe, xp, xd);
        send("R8", 8'h22, 16'h0800, 3'd6, 8'h40, xe, xp, xd);
    endtask

    task automatic t_wide();
        logic [15:0] xe; logic xp; logic [9:0] xd;
        // R9: largest remainder and measurement, odd rank with full parked value.
        send("R9", 8'hFF, 16'h7800, 3'd0, 8'h01, 16'h02FF, 1'b1, 10'h2FF);
        model(8'hFF, 16'h7BFF, 3'd5, 8'hFF, xe, xp, xd);
        send("R9", 8'hFF, 16'h7BFF, 3'd5, 8'hFF, xe, xp, xd);
    endtask

    task automatic t_idle_and_b2b();
        // R10: inputs move, valid stays low.
        @(negedge clk);
        req_valid = 1'b0; meas_dly = 8'hAA; cs_idx = 3'd1; entry_in = 16'hFFFF;
        @(negedge clk);
        check("R10", "rsp_valid", 32'(rsp_valid), 0);
        check("R10", "prog_en", 32'(prog_en), 0);
        // R2: two requests on consecutive edges.
        req_valid = 1'b1; meas_dly = 8'h10; entry_in = 16'h0000; cs_idx = 3'd0; cs_mask = 8'h01;
        @(negedge clk);
        check("R2", "first_valid", 32'(rsp_valid), 1);
        check("R2", "first_entry", 32'(entry_out), 32'h30);
        meas_dly = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "second_valid", 32'(rsp_valid), 1);
        check("R2", "second_entry", 32'(entry_out), 32'h31);
        @(negedge clk);
        check("R2", "drop_valid", 32'(rsp_valid), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_remainder();
        t_pair();
        t_mask();
        t_wide();
        t_idle_and_b2b();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule